// File: doc/BRIEF.md
# Serial Flash Command Engine

This block lets a host processor run one serial-flash transaction at a time through a small byte-wide register window. The host stores a 16-bit serial clock count, an opcode, three address bytes and any outgoing payload bytes in registers on an 8-byte stride. A single write of the start key then launches the transaction. The engine drives chip select and the serial clock. It sends the opcode, the address bytes and the payload as one continuous bit stream, least significant bit of each byte first. The stream runs for exactly the programmed number of clocks, and every input bit is captured into a readable receive window.

Because the host sets the clock count itself, the same engine serves short commands such as write-enable (8 clocks), status (16), identification (40), and reads or page programs of 32 clocks plus 8 per payload byte. Since every byte leaves LSB first, a host that needs MSB-first addresses stores each address byte already bit-reversed. While the transaction runs, the host polls a busy byte. Results are read back from the receive window, which is laid out so that frame byte j appears at offset 0x18 + 8*j.

Top module: `sfce_top`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0 and mosi is 0. The busy byte at offset 0x001 reads 0x00 and every receive byte reads 0x00.
- R2: A write of 0xFF to offset 0x7F8 while idle starts one transaction, which makes cs_n fall exactly once. A write of any other value there starts nothing.
- R3: A transaction produces exactly N rising sclk edges, where N = {byte at 0x000, byte at 0x008} (high byte, low byte). Consecutive rising edges are CLK_DIV system clocks apart, and sclk is high for half of each period.
- R4: The bit sent at rising edge k (k from 0) is bit k mod 8 of frame byte k/8. Frame byte 0 is the opcode at 0x010, bytes 1, 2 and 3 are the values at 0x018, 0x020 and 0x028, and byte 4+i is the payload at 0x030 + 8*i. Bits beyond the frame (WIN_BYTES+4 bytes) are sent as 0.
- R5: mosi changes only in a cycle where sclk is low, and it is stable across every rising sclk edge.
- R6: The miso level at rising edge k is stored in bit k mod 8 of receive byte k/8, readable at 0x018 + 8*(k/8). Receive bytes are cleared when a transaction starts. Bits beyond the frame are dropped, and offset 0x7F0 reads 0x00.
- R7: cs_n falls at least CLK_DIV/2 system clocks before the first rising edge. It rises CLK_DIV/2 system clocks after the last falling edge, and sclk is 0 whenever cs_n is 1.
- R8: The busy byte reads 0x01 from the cycle after the start write until one cycle after cs_n rises. Busy never reads 0 while cs_n is 0.
- R9: A start write while a transaction is running is ignored. No second frame follows.
- R10: Register writes during a transaction are stored but do not change the running stream. The next transaction uses them.
- R11: With N = 0, cs_n pulses low and busy completes with no sclk edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 11 | Byte offset for register writes and reads |
| host_we | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
Directed cases cover three things. The first is short fixed commands: 8, 16 and 40 clocks, which show that status and identification results land at offsets 0x20 and 0x38. The second is a count of 13 that ends inside a byte, which separates partial capture from whole-byte capture. The third is a count that runs 16 clocks past the frame end, which shows zero fill on output and dropped bits on input. A count of zero, a non-key start value, a second start during a run and an opcode change during a run check that the frame is started, held and reloaded correctly. Random transactions with random opcodes, addresses, payload lengths and odd clock counts are compared bit by bit against a bench model of the outgoing stream and of the receive window. They expose ordering, off-by-one and byte-lane faults that the fixed commands alone would not separate.

// File: rtl/sfce_pkg.sv
// Shared constants and types for the serial flash command engine.
// Assumes an 11-bit byte address space with registers on an 8-byte stride.
package sfce_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL,
        ST_GAP
    } seq_state_t;

    localparam int unsigned HDR_BYTES    = 4;
    localparam logic [7:0]  SLOT_CNT_HI  = 8'd0;
    localparam logic [7:0]  SLOT_CNT_LO  = 8'd1;
    localparam logic [7:0]  SLOT_OPCODE  = 8'd2;
    localparam logic [7:0]  SLOT_ADR_HI  = 8'd3;
    localparam logic [7:0]  SLOT_ADR_MID = 8'd4;
    localparam logic [7:0]  SLOT_ADR_LO  = 8'd5;
    localparam int unsigned SLOT_TX_BASE = 6;
    localparam int unsigned SLOT_RX_BASE = 3;
    localparam logic [7:0]  SLOT_START   = 8'd255;
    localparam logic [7:0]  START_KEY    = 8'hFF;
    localparam logic [10:0] BUSY_OFFSET  = 11'h001;

endpackage

// File: rtl/sfce_regs.sv
// Host register file: clock count, opcode, address bytes and payload window.
// Assumes writes land only on 8-byte aligned offsets; a start pulse is
// produced for the start key written to the start slot.
module sfce_regs
    import sfce_pkg::*;
#(
    parameter int unsigned WIN_BYTES = 247,
    localparam int unsigned FRAME_BITS = (WIN_BYTES + HDR_BYTES) * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [10:0]           host_addr,
    input  logic                  host_we,
    input  logic [7:0]            host_wdata,
    output logic [15:0]           clk_count,
    output logic [FRAME_BITS-1:0] tx_frame,
    output logic                  start
);

    logic [7:0] cnt_hi_q, cnt_lo_q, op_q, adr_hi_q, adr_mid_q, adr_lo_q;
    logic [7:0] slot;
    logic       wr_hit;

    assign slot   = host_addr[10:3];
    assign wr_hit = host_we && (host_addr[2:0] == 3'b000);
    assign start  = wr_hit && (slot == SLOT_START) && (host_wdata == START_KEY);

    // Header registers: count, opcode and the three address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_hi_q  <= '0;
            cnt_lo_q  <= '0;
            op_q      <= '0;
            adr_hi_q  <= '0;
            adr_mid_q <= '0;
            adr_lo_q  <= '0;
        end else if (wr_hit) begin
            unique case (slot)
                SLOT_CNT_HI:  cnt_hi_q  <= host_wdata;
                SLOT_CNT_LO:  cnt_lo_q  <= host_wdata;
                SLOT_OPCODE:  op_q      <= host_wdata;
                SLOT_ADR_HI:  adr_hi_q  <= host_wdata;
                SLOT_ADR_MID: adr_mid_q <= host_wdata;
                SLOT_ADR_LO:  adr_lo_q  <= host_wdata;
                default: ;
            endcase
        end
    end

    assign clk_count        = {cnt_hi_q, cnt_lo_q};
    assign tx_frame[7:0]    = op_q;
    assign tx_frame[15:8]   = adr_hi_q;
    assign tx_frame[23:16]  = adr_mid_q;
    assign tx_frame[31:24]  = adr_lo_q;

    for (genvar i = 0; i < WIN_BYTES; i++) begin : g_tx
        localparam logic [7:0] MY_SLOT = 8'(SLOT_TX_BASE + i);
        logic [7:0] byte_q;
        // One payload byte register per window slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (wr_hit && slot == MY_SLOT)
                byte_q <= host_wdata;
        end
        assign tx_frame[8*(HDR_BYTES+i) +: 8] = byte_q;
    end

endmodule

// File: rtl/sfce_seq.sv
// Shift sequencer and serial clock divider. On start it snapshots the count
// and the outgoing frame, then runs lead, N clock periods and trail phases.
// Assumes CLK_DIV is even and at least 2; mosi moves on falling edges.
module sfce_seq
    import sfce_pkg::*;
#(
    parameter int unsigned CLK_DIV   = 4,
    parameter int unsigned WIN_BYTES = 247,
    localparam int unsigned FRAME_BITS = (WIN_BYTES + HDR_BYTES) * 8,
    localparam int unsigned FBW        = $clog2(FRAME_BITS),
    localparam int unsigned HALF       = CLK_DIV / 2,
    localparam int unsigned TW         = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [15:0]           clk_count,
    input  logic [FRAME_BITS-1:0] tx_frame,
    output logic                  sclk,
    output logic                  cs_n,
    output logic                  mosi,
    output logic                  busy,
    output logic                  cap_en,
    output logic                  cap_clr,
    output logic [15:0]           cap_idx,
    output logic [15:0]           act_count
);

    localparam logic [TW-1:0] TMR_LOAD   = TW'(HALF - 1);
    localparam logic [15:0]   FRAME_LIM  = 16'(FRAME_BITS);

    seq_state_t            st;
    logic [TW-1:0]         tmr;
    logic [15:0]           bit_idx;
    logic [15:0]           nxt_idx;
    logic [FRAME_BITS-1:0] act_frame;
    logic                  tmr_done;

    assign nxt_idx  = bit_idx + 16'd1;
    assign tmr_done = (tmr == '0);

    // Select one outgoing bit of the active frame, zero past its end.
    function automatic logic frame_bit(input logic [15:0] k);
        if (k < FRAME_LIM)
            return act_frame[k[FBW-1:0]];
        return 1'b0;
    endfunction

    // Phase machine driving chip select, serial clock and serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            tmr       <= '0;
            bit_idx   <= '0;
            act_count <= '0;
            act_frame <= '0;
            sclk      <= 1'b0;
            cs_n      <= 1'b1;
            mosi      <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st        <= ST_LEAD;
                        tmr       <= TMR_LOAD;
                        bit_idx   <= '0;
                        act_count <= clk_count;
                        act_frame <= tx_frame;
                        cs_n      <= 1'b0;
                        mosi      <= (clk_count != 16'd0) ? tx_frame[0] : 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (tmr_done) begin
                        tmr <= TMR_LOAD;
                        if (act_count == 16'd0) begin
                            st <= ST_TRAIL;
                        end else begin
                            st   <= ST_HIGH;
                            sclk <= 1'b1;
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (tmr_done) begin
                        tmr     <= TMR_LOAD;
                        sclk    <= 1'b0;
                        bit_idx <= nxt_idx;
                        if (nxt_idx == act_count) begin
                            st   <= ST_TRAIL;
                            mosi <= 1'b0;
                        end else begin
                            st   <= ST_LOW;
                            mosi <= frame_bit(nxt_idx);
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_LOW: begin
                    if (tmr_done) begin
                        tmr  <= TMR_LOAD;
                        st   <= ST_HIGH;
                        sclk <= 1'b1;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (tmr_done) begin
                        cs_n <= 1'b1;
                        st   <= ST_GAP;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_GAP: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Capture strobe coincides with the system edge that raises sclk.
    always_comb begin
        cap_en  = tmr_done && ((st == ST_LOW) ||
                  (st == ST_LEAD && act_count != 16'd0));
        cap_idx = bit_idx;
        cap_clr = (st == ST_IDLE) && start;
        busy    = (st != ST_IDLE);
    end

endmodule

// File: rtl/sfce_capture.sv
// Receive window: one byte per frame position, filled bit by bit from miso.
// Assumes cap_idx counts rising edges from 0; bits past the frame are dropped.
module sfce_capture
    import sfce_pkg::*;
#(
    parameter int unsigned WIN_BYTES = 247,
    localparam int unsigned FRAME_BYTES = WIN_BYTES + HDR_BYTES,
    localparam int unsigned FRAME_BITS  = FRAME_BYTES * 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        cap_en,
    input  logic [15:0] cap_idx,
    input  logic        miso,
    input  logic [7:0]  rd_idx,
    output logic [7:0]  rd_byte
);

    localparam logic [7:0] RD_LIM = 8'(FRAME_BYTES);

    logic [FRAME_BITS-1:0] rx_flat;

    for (genvar j = 0; j < FRAME_BYTES; j++) begin : g_rx
        localparam logic [12:0] MY_BYTE = 13'(j);
        logic [7:0] byte_q;
        // Store the sampled bit into its lane of this receive byte.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                byte_q <= '0;
            else if (cap_en && cap_idx[15:3] == MY_BYTE)
                byte_q[cap_idx[2:0]] <= miso;
        end
        assign rx_flat[8*j +: 8] = byte_q;
    end

    // Read selection of one receive byte, zero outside the window.
    always_comb begin
        rd_byte = 8'h00;
        if (rd_idx < RD_LIM)
            rd_byte = rx_flat[{rd_idx, 3'b000} +: 8];
    end

endmodule

// File: rtl/sfce_top.sv
// Serial flash command engine top: register file, sequencer, receive window
// and the host read multiplexer. Assumes WIN_BYTES <= 247 so that every slot
// fits below the start slot on the 8-byte stride.
module sfce_top
    import sfce_pkg::*;
#(
    parameter int unsigned CLK_DIV   = 4,
    parameter int unsigned WIN_BYTES = 247,
    localparam int unsigned FRAME_BYTES = WIN_BYTES + HDR_BYTES,
    localparam int unsigned FRAME_BITS  = FRAME_BYTES * 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [10:0] host_addr,
    input  logic        host_we,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);

    localparam logic [7:0] RX_FIRST = 8'(SLOT_RX_BASE);
    localparam logic [7:0] RX_END   = 8'(SLOT_RX_BASE + FRAME_BYTES);

    logic [15:0]           clk_count;
    logic [FRAME_BITS-1:0] tx_frame;
    logic                  start;
    logic                  busy;
    logic                  cap_en;
    logic                  cap_clr;
    logic [15:0]           cap_idx;
    logic [15:0]           act_count;
    logic [7:0]            rd_slot;
    logic [7:0]            rd_idx;
    logic [7:0]            rx_byte;

    sfce_regs #(.WIN_BYTES(WIN_BYTES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .clk_count  (clk_count),
        .tx_frame   (tx_frame),
        .start      (start)
    );

    sfce_seq #(.CLK_DIV(CLK_DIV), .WIN_BYTES(WIN_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .clk_count (clk_count),
        .tx_frame  (tx_frame),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .busy      (busy),
        .cap_en    (cap_en),
        .cap_clr   (cap_clr),
        .cap_idx   (cap_idx),
        .act_count (act_count)
    );

    sfce_capture #(.WIN_BYTES(WIN_BYTES)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cap_clr),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .miso    (miso),
        .rd_idx  (rd_idx),
        .rd_byte (rx_byte)
    );

    assign rd_slot = host_addr[10:3];
    assign rd_idx  = rd_slot - RX_FIRST;

    // Host read map: busy byte, then the receive window on the stride.
    always_comb begin
        host_rdata = 8'h00;
        if (host_addr == BUSY_OFFSET)
            host_rdata = {7'b0, busy};
        else if (host_addr[2:0] == 3'b000 && rd_slot >= RX_FIRST && rd_slot < RX_END)
            host_rdata = rx_byte;
    end

endmodule

// File: rtl/sfce_chk.sv
// Protocol checker for the serial flash command engine, bound to sfce_top.
// Watches chip select, serial clock, serial output and the busy state.
module sfce_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sclk,
    input logic        cs_n,
    input logic        mosi,
    input logic        busy,
    input logic [15:0] act_count
);

    logic [15:0] edge_cnt;
    logic        sclk_d;

    // Count rising serial clock edges inside the current chip-select frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            sclk_d   <= 1'b0;
        end else begin
            sclk_d <= sclk;
            if (cs_n)
                edge_cnt <= '0;
            else if (sclk && !sclk_d)
                edge_cnt <= edge_cnt + 16'd1;
        end
    end

    p_edge_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt <= act_count);

    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    p_mosi_move_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> !sclk);

    p_idle_clock_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_select_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    p_busy_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cs_n && $past(cs_n)));

endmodule

bind sfce_top sfce_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .busy      (busy),
    .act_count (act_count)
);

// File: tb/sim_sfce_top.sv
`timescale 1ns/1ps
module sim_sfce_top;

    localparam int CLK_DIV     = 4;
    localparam int WIN         = 247;
    localparam int FRAME_BYTES = WIN + 4;
    localparam int HALF        = CLK_DIV / 2;
    localparam int TCLK        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] host_addr = '0;
    logic        host_we = 1'b0;
    logic [7:0]  host_wdata = '0;
    wire  [7:0]  host_rdata;
    wire         sclk, cs_n, mosi;
    logic        miso = 1'b0;

    always #2 clk = ~clk;

    sfce_top #(.CLK_DIV(CLK_DIV), .WIN_BYTES(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .sclk(sclk),
        .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Device responder state.
    int         n_rise = 0;
    int         n_csfall = 0;
    int         lead_bad = 0;
    int         period_bad = 0;
    longint     t_csfall = 0;
    longint     t_lastrise = 0;
    logic       sent [0:4095];
    logic [7:0] resp [0:255];

    // Bench model of the host registers.
    int         m_cnt;
    logic [7:0] m_op, m_ahi, m_amid, m_alo;
    logic [7:0] m_data [0:WIN-1];

    function automatic logic resp_bit(input int k);
        if (k / 8 < 256) return resp[k/8][k%8];
        return 1'b0;
    endfunction

    function automatic logic exp_bit(input int k);
        int b;
        b = k / 8;
        if (b == 0) return m_op[k%8];
        if (b == 1) return m_ahi[k%8];
        if (b == 2) return m_amid[k%8];
        if (b == 3) return m_alo[k%8];
        if (b < FRAME_BYTES) return m_data[b-4][k%8];
        return 1'b0;
    endfunction

    function automatic logic [7:0] exp_rx(input int j);
        logic [7:0] v;
        for (int b = 0; b < 8; b++)
            v[b] = (8*j + b < m_cnt) ? resp_bit(8*j + b) : 1'b0;
        return v;
    endfunction

    always @(negedge cs_n) begin
        n_csfall++;
        t_csfall = $time;
    end

    always @(negedge cs_n or negedge sclk) miso = resp_bit(n_rise);

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (n_rise == 0 && ($time - t_csfall) < HALF*TCLK) lead_bad++;
            if (n_rise > 0 && ($time - t_lastrise) != CLK_DIV*TCLK) period_bad++;
            t_lastrise = $time;
            if (n_rise < 4096) sent[n_rise] = mosi;
            n_rise++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, expv);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic set_hdr(input int cnt, input logic [7:0] op,
                           input logic [7:0] ahi, input logic [7:0] amid,
                           input logic [7:0] alo);
        wr(11'h000, 8'(cnt >> 8)); wr(11'h008, 8'(cnt));
        wr(11'h010, op); wr(11'h018, ahi); wr(11'h020, amid); wr(11'h028, alo);
        m_cnt = cnt; m_op = op; m_ahi = ahi; m_amid = amid; m_alo = alo;
    endtask

    task automatic set_data(input int i, input logic [7:0] v);
        wr(11'(48 + 8*i), v);
        m_data[i] = v;
    endtask

    task automatic fill_resp();
        for (int j = 0; j < 256; j++) resp[j] = 8'($urandom);
    endtask

    int csf0;

    task automatic start_txn();
        logic [7:0] v;
        n_rise = 0;
        csf0 = n_csfall;
        wr(11'h7F8, 8'hFF);
        rd(11'h001, v);
        check(v == 8'h01, "R8", "busy right after start", v, 1);
    endtask

    task automatic finish_txn(input string tag);
        logic [7:0] v;
        int bad, fk, lim;
        logic fg, fe;
        for (int w = 0; w < 40000; w++) begin
            rd(11'h001, v);
            if (v == 8'h00) break;
        end
        check(cs_n == 1'b1, "R8", {tag, " cs released at busy clear"}, cs_n, 1);
        check(n_rise == m_cnt, "R3", {tag, " rising edge count"}, n_rise, m_cnt);
        check(n_csfall == csf0 + 1, "R2", {tag, " one frame per start"}, n_csfall - csf0, 1);
        bad = 0; fk = 0; fg = 0; fe = 0;
        lim = (m_cnt < 4096) ? m_cnt : 4096;
        for (int k = 0; k < lim; k++) begin
            if (sent[k] !== exp_bit(k)) begin
                if (bad == 0) begin fk = k; fg = sent[k]; fe = exp_bit(k); end
                bad++;
            end
        end
        if (bad != 0) $display("  first stream mismatch at bit %0d", fk);
        check(bad == 0, "R4", {tag, " outgoing stream"}, fg, fe);
        bad = 0;
        for (int j = 0; j < FRAME_BYTES; j++) begin
            rd(11'(24 + 8*j), v);
            if (v !== exp_rx(j)) begin
                if (bad == 0) $display("  first receive mismatch at byte %0d", j);
                if (bad == 0) begin fk = v; fe = 0; end
                bad++;
            end
        end
        check(bad == 0, "R6", {tag, " receive window"}, bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int nb;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < WIN; i++) m_data[i] = 8'h00;
        for (int j = 0; j < 256; j++) resp[j] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1", "pins after reset",
              {cs_n, sclk, mosi}, 3'b100);
        rd(11'h001, v);
        check(v == 8'h00, "R1", "busy after reset", v, 0);
        rd(11'h020, v);
        check(v == 8'h00, "R1", "receive byte after reset", v, 0);

        // R2 non-key start value is ignored
        set_hdr(8, 8'h60, 8'h00, 8'h00, 8'h00);
        csf0 = n_csfall;
        wr(11'h7F8, 8'h7F);
        repeat (10) @(negedge clk);
        rd(11'h001, v);
        check(n_csfall == csf0 && v == 8'h00, "R2", "non-key start ignored", n_csfall - csf0, 0);

        // write enable style, 8 clocks
        fill_resp();
        start_txn(); finish_txn("wren");

        // status style, 16 clocks, result at 0x20
        fill_resp();
        set_hdr(16, 8'hA0, 8'h05, 8'h00, 8'h00);
        start_txn(); finish_txn("status");
        rd(11'h020, v);
        check(v == resp[1], "R6", "status byte at 0x20", v, resp[1]);

        // identification style, 40 clocks, result at 0x38
        fill_resp();
        set_hdr(40, 8'hD5, 8'h00, 8'h00, 8'h00);
        start_txn(); finish_txn("ident");
        rd(11'h038, v);
        check(v == resp[4], "R6", "ident byte at 0x38", v, resp[4]);

        // partial byte: 13 clocks
        fill_resp();
        set_hdr(13, 8'h3B, 8'hC4, 8'h11, 8'h22);
        start_txn(); finish_txn("partial");
        rd(11'h020, v);
        check(v == {3'b000, resp[1][4:0]}, "R6", "partial byte lanes", v, {3'b000, resp[1][4:0]});

        // R11 zero count
        set_hdr(0, 8'hE3, 8'h00, 8'h00, 8'h00);
        start_txn(); finish_txn("zero");
        check(n_rise == 0, "R11", "no edges for zero count", n_rise, 0);

        // R9 / R10: second start and opcode change while running
        fill_resp();
        set_hdr(40, 8'hD5, 8'h81, 8'h42, 8'h18);
        start_txn();
        wr(11'h010, 8'h3C);
        wr(11'h7F8, 8'hFF);
        finish_txn("retrigger");
        check(n_csfall == csf0 + 1, "R9", "start during run ignored", n_csfall - csf0, 1);
        repeat (20) @(negedge clk);
        check(n_csfall == csf0 + 1 && cs_n, "R9", "no late frame", n_csfall - csf0, 1);
        m_op = 8'h3C;
        start_txn(); finish_txn("R10 reload");
        check(sent[2] == 1'b1 && sent[0] == 1'b0, "R10", "new opcode in next frame", sent[2], 1);

        // beyond the frame: all payload bytes and 16 extra clocks
        fill_resp();
        set_hdr(FRAME_BYTES*8 + 16, 8'hC0, 8'h9A, 8'h5C, 8'h01);
        for (int i = 0; i < WIN; i++) set_data(i, 8'($urandom));
        start_txn(); finish_txn("overrun");
        rd(11'h7F0, v);
        check(v == 8'h00, "R6", "offset 0x7F0 reads zero", v, 0);

        // random transactions
        for (int t = 0; t < 8; t++) begin
            fill_resp();
            nb = $urandom % 24;
            for (int i = 0; i < nb; i++) set_data(i, 8'($urandom));
            if (t % 3 == 0)
                set_hdr(1 + $urandom % 300, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            else
                set_hdr(32 + 8*nb, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            start_txn(); finish_txn("random");
        end

        check(lead_bad == 0, "R7", "chip select lead time", lead_bad, 0);
        check(period_bad == 0, "R3", "serial clock period", period_bad, 0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule